// File: doc/BRIEF.md
# Transactional Read/Write-Set Conflict Tracker

This block is a small direct-mapped tag store that sits beside one core's cache. While a hardware transaction runs, it keeps two tracking bits per line. One bit records that the transaction loaded from the line. The other records that the transaction stored to it. Incoming coherence requests from other cores are compared with these bits. When a request collides with the transaction's footprint, the block reports a conflict along with a code that gives the kind of collision. The contention policy that decides what to do about the conflict lives elsewhere.

The core sends three kinds of input. The first is a begin, commit or abort command. The second is its local load and store hits, each with a line address. The third is each snooped shared or exclusive request, also with a line address. On commit, every tracking bit is cleared in a single cycle and the lines stay resident. On abort, the bits are cleared in the same way, and every line the transaction touched is also dropped from the store. A transactional access that needs a slot already held by another tracked line does not evict that line. It raises an overflow pulse instead.

Top module: `txn_set_tracker`

## Requirements
- R1: A load accepted while a transaction is open marks its line as read. After that, an exclusive snoop to the line reports a conflict.
- R2: A shared snoop that hits a line marked as written reports a conflict with type code 01 (read against write).
- R3: An exclusive snoop that hits a line marked as written reports type code 10 (write against write). This holds even when the line is also marked as read.
- R4: An exclusive snoop that hits a line marked only as read reports type code 11 (write against read).
- R5: No conflict is reported, and the type code is 00, in three cases: a shared snoop to a line marked only as read, a snoop whose tag misses or whose line is invalid, and any snoop while no transaction is open.
- R6: `conflict_o` and `conflict_type_o` are registered. They reflect the snoop of the previous cycle only, so each snoop yields at most a one-cycle pulse.
- R7: A commit clears every tracking bit at once and closes the transaction. Lines remain valid, so a later access to one of them still hits.
- R8: An abort clears every tracking bit and invalidates each line that had either bit set. Lines that were not touched by the transaction stay valid.
- R9: A transactional access whose slot holds a different tag with a tracking bit set raises `overflow_o` for one cycle. The resident line, its tag and its bits are left unchanged.
- R10: Outside a transaction, an access fills or hits its line without setting any tracking bit.
- R11: After reset, all outputs are 0. A begin command (`cmd_i`=01) sets `in_txn_o` from the next cycle. A commit (10) or abort (11) clears it. Code 00 does nothing.
- R12: `acc_hit_o` is 1 in the cycle after an access whose line was valid with a matching tag. The address splits into a line index (low bits) and a tag (high bits).
- R13: An access presented in the same cycle as a commit or abort is ignored. It reports no hit, raises no overflow, fills nothing and marks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | 00 none, 01 begin, 10 commit, 11 abort |
| acc_valid_i | input | 1 | Local access this cycle |
| acc_write_i | input | 1 | Local access is a store |
| acc_addr_i | input | ADDR_W | Line address of the local access |
| snp_valid_i | input | 1 | Snooped request this cycle |
| snp_excl_i | input | 1 | Snoop is exclusive (1) or shared (0) |
| snp_addr_i | input | ADDR_W | Line address of the snoop |
| acc_hit_o | output | 1 | Previous access hit a valid line |
| overflow_o | output | 1 | Previous access could not be tracked |
| conflict_o | output | 1 | Previous snoop conflicted |
| conflict_type_o | output | 2 | Conflict kind: 01 RW, 10 WW, 11 WR, 00 none |
| in_txn_o | output | 1 | Transaction open |

## Verification
Every result comes from a register. The hit, overflow, conflict and type outputs are each due one clock edge after the cycle that carried the access or snoop. `in_txn_o` changes one edge after the command. The bench applies each stimulus on a falling edge and keeps a model of the tag store that it updates at the same point. It compares all outputs at the next falling edge, which is one full edge after the registers load, before the next stimulus is driven. Directed steps cover the conflict classes, overflow, commit versus abort, and a command colliding with an access. Seeded random traffic over a small address pool then mixes these events.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_BEGIN  = 2'b01,
    CMD_COMMIT = 2'b10,
    CMD_ABORT  = 2'b11
  } txn_cmd_e;

  typedef enum logic [1:0] {
    CF_NONE  = 2'b00,
    CF_RD_WR = 2'b01,
    CF_WR_WR = 2'b10,
    CF_WR_RD = 2'b11
  } conflict_e;
endpackage

// File: rtl/txn_ctrl.sv
module txn_ctrl
  import txn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  output logic       in_txn_o,
  output logic       clear_o,
  output logic       abort_o
);
  logic in_txn_q;

  assign clear_o  = (cmd_i == CMD_COMMIT) || (cmd_i == CMD_ABORT);
  assign abort_o  = (cmd_i == CMD_ABORT);
  assign in_txn_o = in_txn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 in_txn_q <= 1'b0;
    else if (cmd_i == CMD_BEGIN) in_txn_q <= 1'b1;
    else if (clear_o)            in_txn_q <= 1'b0;
  end

  a_r11_begin_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_BEGIN) |=> in_txn_q);
  a_r11_end_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == CMD_COMMIT) || (cmd_i == CMD_ABORT)) |=> !in_txn_q);
endmodule

// File: rtl/txn_line.sv
module txn_line #(
  parameter int unsigned TAG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             is_wr_i,
  input  logic             mark_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             clear_i,
  input  logic             inval_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             hit_o,
  output logic             block_o
);
  logic             valid_q, rd_q, wr_q;
  logic [TAG_W-1:0] tag_q;
  logic             tracked;

  assign tracked = rd_q | wr_q;
  assign hit_o   = valid_q && (tag_q == tag_i);
  assign block_o = upd_i && mark_i && !hit_o && tracked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (clear_i) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      if (inval_i && tracked) valid_q <= 1'b0;
    end else if (upd_i) begin
      if (hit_o) begin
        rd_q <= rd_q | (mark_i & ~is_wr_i);
        wr_q <= wr_q | (mark_i & is_wr_i);
      end else if (!tracked) begin
        valid_q <= 1'b1;
        tag_q   <= tag_i;
        rd_q    <= mark_i & ~is_wr_i;
        wr_q    <= mark_i & is_wr_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign rd_o    = rd_q;
  assign wr_o    = wr_q;

  a_r7_bits_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!rd_q && !wr_q));
  a_r8_tracked_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_i && tracked) |=> !valid_q);
  a_r9_victim_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_o && !clear_i) |=> (valid_q && $stable(tag_q)));
  a_r10_no_mark_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !mark_i && !tracked && !clear_i) |=> !(rd_q || wr_q));
endmodule

// File: rtl/txn_snoop_check.sv
module txn_snoop_check
  import txn_pkg::*;
#(
  parameter int unsigned TAG_W = 7
) (
  input  logic             snp_valid_i,
  input  logic             snp_excl_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             line_valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic             line_rd_i,
  input  logic             line_wr_i,
  output logic             conflict_o,
  output logic [1:0]       type_o
);
  logic hit;
  conflict_e kind;

  assign hit = snp_valid_i && line_valid_i && (line_tag_i == snp_tag_i);

  always_comb begin
    kind = CF_NONE;
    if (hit) begin
      if (snp_excl_i) begin
        if (line_wr_i)      kind = CF_WR_WR;  // write wins over read
        else if (line_rd_i) kind = CF_WR_RD;
      end else if (line_wr_i) begin
        kind = CF_RD_WR;
      end
    end
  end

  assign conflict_o = (kind != CF_NONE);
  assign type_o     = kind;
endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txn_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              snp_valid_i,
  input  logic              snp_excl_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              acc_hit_o,
  output logic              overflow_o,
  output logic              conflict_o,
  output logic [1:0]        conflict_type_o,
  output logic              in_txn_o
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic             in_txn, clear, abort;
  logic [IDX_W-1:0] acc_idx, snp_idx;
  logic [TAG_W-1:0] acc_tag, snp_tag;

  logic [NUM_LINES-1:0] valid_v, rd_v, wr_v, hit_v, block_v;
  logic [TAG_W-1:0]     tag_a [NUM_LINES];

  logic       snp_conf;
  logic [1:0] snp_type;
  logic       acc_hit_q, overflow_q, conflict_q;
  logic [1:0] type_q;

  assign acc_idx = acc_addr_i[IDX_W-1:0];
  assign acc_tag = acc_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  txn_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd_i),
    .in_txn_o (in_txn),
    .clear_o  (clear),
    .abort_o  (abort)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    txn_line #(.TAG_W(TAG_W)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_i   (acc_valid_i && !clear && (acc_idx == IDX_W'(i))),
      .is_wr_i (acc_write_i),
      .mark_i  (in_txn),
      .tag_i   (acc_tag),
      .clear_i (clear),
      .inval_i (abort),
      .valid_o (valid_v[i]),
      .tag_o   (tag_a[i]),
      .rd_o    (rd_v[i]),
      .wr_o    (wr_v[i]),
      .hit_o   (hit_v[i]),
      .block_o (block_v[i])
    );
  end

  txn_snoop_check #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid_i  (snp_valid_i),
    .snp_excl_i   (snp_excl_i),
    .snp_tag_i    (snp_tag),
    .line_valid_i (valid_v[snp_idx]),
    .line_tag_i   (tag_a[snp_idx]),
    .line_rd_i    (rd_v[snp_idx]),
    .line_wr_i    (wr_v[snp_idx]),
    .conflict_o   (snp_conf),
    .type_o       (snp_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_hit_q  <= 1'b0;
      overflow_q <= 1'b0;
      conflict_q <= 1'b0;
      type_q     <= CF_NONE;
    end else begin
      acc_hit_q  <= acc_valid_i && !clear && hit_v[acc_idx];
      overflow_q <= |block_v;
      conflict_q <= snp_conf;
      type_q     <= snp_type;
    end
  end

  assign acc_hit_o       = acc_hit_q;
  assign overflow_o      = overflow_q;
  assign conflict_o      = conflict_q;
  assign conflict_type_o = type_q;
  assign in_txn_o        = in_txn;

  a_r9_ovf_not_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !acc_hit_o);
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_txn_o && snp_valid_i) |=> !conflict_o);
  a_r5_shared_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !snp_excl_i && !wr_v[snp_idx]) |=> !conflict_o);
  a_r6_no_snoop_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |=> (!conflict_o && conflict_type_o == 2'b00));
  a_r13_cmd_drops_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && clear) |=> (!acc_hit_o && !overflow_o));
endmodule

// File: tb/txn_set_tracker_tb_top.sv
module txn_set_tracker_tb_top;
  localparam int ADDR_W = 10;
  localparam int NL     = 8;
  localparam int IDX_W  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = '0;
  logic acc_v = 0, acc_w = 0, snp_v = 0, snp_x = 0;
  logic [ADDR_W-1:0] acc_a = '0, snp_a = '0;
  logic hit_o, ovf_o, conf_o, in_o;
  logic [1:0] type_o;

  always #5 clk = ~clk;

  txn_set_tracker #(.ADDR_W(ADDR_W), .NUM_LINES(NL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd),
    .acc_valid_i(acc_v), .acc_write_i(acc_w), .acc_addr_i(acc_a),
    .snp_valid_i(snp_v), .snp_excl_i(snp_x), .snp_addr_i(snp_a),
    .acc_hit_o(hit_o), .overflow_o(ovf_o), .conflict_o(conf_o),
    .conflict_type_o(type_o), .in_txn_o(in_o)
  );

  int total = 0, fails = 0;
  bit m_valid [NL], m_rd [NL], m_wr [NL];
  int m_tag [NL];
  bit m_in = 0;

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int mk(int t, int i);
    return (t << IDX_W) | i;
  endfunction

  // one stimulus cycle, checked one edge later
  task automatic step(string tag, int c, bit av, bit aw, int aa, bit sv, bit sx, int sa);
    int ai, at, si, st, etype;
    bit clr, ehit, eovf;
    string ct;
    cmd = 2'(c); acc_v = av; acc_w = aw; acc_a = ADDR_W'(aa);
    snp_v = sv; snp_x = sx; snp_a = ADDR_W'(sa);
    ai = aa % NL; at = aa / NL; si = sa % NL; st = sa / NL;
    clr = (c == 2) || (c == 3);
    etype = 0;
    if (sv && m_valid[si] && m_tag[si] == st) begin
      if (sx) etype = m_wr[si] ? 2 : (m_rd[si] ? 3 : 0);
      else    etype = m_wr[si] ? 1 : 0;
    end
    ehit = av && !clr && m_valid[ai] && m_tag[ai] == at;
    eovf = av && !clr && m_in && !ehit && (m_rd[ai] || m_wr[ai]);
    if (av && !clr) begin
      if (ehit) begin
        m_rd[ai] |= m_in && !aw;
        m_wr[ai] |= m_in && aw;
      end else if (!(m_rd[ai] || m_wr[ai])) begin
        m_valid[ai] = 1; m_tag[ai] = at;
        m_rd[ai] = m_in && !aw; m_wr[ai] = m_in && aw;
      end
    end
    if (c == 1) m_in = 1;
    if (clr) begin
      for (int i = 0; i < NL; i++) begin
        if (c == 3 && (m_rd[i] || m_wr[i])) m_valid[i] = 0;
        m_rd[i] = 0; m_wr[i] = 0;
      end
      m_in = 0;
    end
    @(negedge clk);
    ct = (tag != "") ? tag : (etype == 1 ? "R2" : etype == 2 ? "R3" : etype == 3 ? "R4" : "R5");
    chk(ct, "conflict", int'(conf_o), int'(etype != 0));
    chk(ct, "type", int'(type_o), etype);
    chk(tag != "" ? tag : "R12", "acc_hit", int'(hit_o), int'(ehit));
    chk(tag != "" ? tag : "R9", "overflow", int'(ovf_o), int'(eovf));
    chk(tag != "" ? tag : "R11", "in_txn", int'(in_o), int'(m_in));
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset conflict", int'(conf_o), 0);
    chk("R11", "reset type", int'(type_o), 0);
    chk("R11", "reset hit", int'(hit_o), 0);
    chk("R11", "reset overflow", int'(ovf_o), 0);
    chk("R11", "reset in_txn", int'(in_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R11", 1, 0, 0, 0, 0, 0, 0);                       // begin
    step("R1",  0, 1, 0, mk(1,2), 0, 0, 0);                 // load A
    step("R5",  0, 0, 0, 0, 1, 0, mk(1,2));                 // shared to R-only
    step("R1",  0, 0, 0, 0, 1, 1, mk(1,2));                 // excl to R -> 11
    step("R4",  0, 0, 0, 0, 1, 1, mk(1,2));
    step("R2",  0, 1, 1, mk(2,5), 0, 0, 0);                 // store B
    step("R2",  0, 0, 0, 0, 1, 0, mk(2,5));                 // shared to W -> 01
    step("R12", 0, 1, 0, mk(2,5), 0, 0, 0);                 // load B hits
    step("R3",  0, 0, 0, 0, 1, 1, mk(2,5));                 // excl to R+W -> 10
    step("R5",  0, 0, 0, 0, 1, 1, mk(3,5));                 // tag miss
    step("R9",  0, 1, 0, mk(4,2), 0, 0, 0);                 // overflow
    step("R9",  0, 0, 0, 0, 1, 1, mk(1,2));                 // victim kept
    step("R6",  0, 0, 0, 0, 0, 0, 0);                       // pulse gone
    step("R7",  2, 0, 0, 0, 0, 0, 0);                       // commit
    step("R7",  0, 0, 0, 0, 1, 1, mk(2,5));                 // bits gone
    step("R7",  0, 1, 0, mk(2,5), 0, 0, 0);                 // still valid
    step("R10", 0, 1, 1, mk(5,7), 0, 0, 0);                 // fill outside
    step("R10", 0, 0, 0, 0, 1, 1, mk(5,7));                 // unmarked
    step("R10", 0, 1, 0, mk(5,7), 0, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 0);
    step("R8",  0, 1, 1, mk(1,2), 0, 0, 0);
    step("R8",  0, 1, 0, mk(6,0), 0, 0, 0);
    step("R13", 3, 1, 0, mk(7,3), 0, 0, 0);                 // abort + access
    step("R13", 0, 1, 0, mk(7,3), 0, 0, 0);                 // was not filled
    step("R8",  0, 1, 0, mk(1,2), 0, 0, 0);                 // invalidated
    step("R8",  0, 1, 0, mk(6,0), 0, 0, 0);
    step("R8",  0, 1, 0, mk(5,7), 0, 0, 0);                 // untouched kept
    idle("R6");

    r = $urandom(32'h5eed);
    for (int n = 0; n < 3000; n++) begin
      int c, p;
      p = $urandom_range(99);
      c = (p < 5) ? 1 : (p < 8) ? 2 : (p < 11) ? 3 : 0;
      step("", c, 1'($urandom_range(1)), 1'($urandom_range(1)),
           mk($urandom_range(3), $urandom_range(NL-1)),
           1'($urandom_range(1)), 1'($urandom_range(1)),
           mk($urandom_range(3), $urandom_range(NL-1)));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule